// File: doc/BRIEF.md
# Clock Phase Alignment Sequencer

This block finds a safe setting for a 64-step phase delay line. It does this by walking a 6-bit phase setting and watching a one-bit phase comparator. Each trial has four parts. The block drives the setting, waits a settle interval and inverts a load strobe so the delay line takes the new value. On the next cycle it samples the comparator. Adjustments are counted in a 16-bit counter that saturates, and the sequence ends with a one-cycle success or failure pulse.

In edge mode the block first hunts for a comparator change from 1 to 0. It then checks that the edge is real by probing a few settings on both sides of it. Once the edge is confirmed it hunts for it a second time. The final setting is the one just below the edge. A false or noisy edge starts a fresh attempt from wherever the search stopped. The attempts are limited in number and the adjustments share one global budget.

In status mode a multi-bit comparator reading steers the setting up or down until the reading equals a target code.

Top module: `phase_align_seq`

## Requirements
- R1: During and after synchronous reset, `phase_o` is 0, `load_o` is 0, `done_o` and `fail_o` are 0 and `adj_count_o` is 0.
- R2: In every trial, `phase_o` holds its value for SETTLE_CYC clock cycles before `load_o` inverts. The comparator is sampled on the cycle after the inversion. Every trial adds exactly one to `adj_count_o`.
- R3: While searching in edge mode (`mode_i`=0), a sample of 0 lowers the setting by one and a sample of 1 raises it by one. The search ends when two consecutive samples of that search read 1 and then 0. The setting that read 0 is the edge. Every search starts with no previous sample.
- R4: After the first search finds edge E, the block validates it in three steps. (1) Settings E+1 to E+5 must each read 0. (2) Then E+4, E+3 and E+2 must each read 0. (3) Then E+1 down to E-3 are tried, and E-3 must read 1. A failure in any step ends the attempt, and the next attempt begins with a new first search at the current setting.
- R5: After validation a second search runs. When it finds edge E, the setting becomes E-1. After one more settle interval `load_o` inverts and `done_o` pulses together with that inversion. This final load does not add to `adj_count_o`.
- R6: At most MAX_TRIES (10) attempts are made. If the last attempt fails validation, `fail_o` pulses.
- R7: When a trial brings `adj_count_o` to MAX_ADJ (default 65535), the run stops with a `fail_o` pulse. The counter then holds MAX_ADJ and never goes past it.
- R8: In status mode (`mode_i`=1), a sampled `status_i` above 15 raises the setting by one and a value below 15 lowers it by one. A value equal to 15 ends the run with `done_o`, with no change of setting and no extra load.
- R9: `start_i` is ignored while a run is active. `done_o` and `fail_o` are single-cycle pulses and never occur together. After a run ends, `phase_o` and `adj_count_o` hold until the next start.
- R10: All steps of the setting wrap modulo 64. For example, an edge found at 0 gives a final setting of 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (sampled only when idle) |
| mode_i | input | 1 | 0: edge search, 1: status steering |
| cmp_i | input | 1 | One-bit phase comparator reading |
| status_i | input | 5 | Multi-bit comparator reading for status mode |
| init_phase_i | input | 6 | Setting used by the first trial |
| phase_o | output | 6 | Phase setting driven to the delay line |
| load_o | output | 1 | Load strobe, inverted once per trial |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| adj_count_o | output | 16 | Adjustments made in the current or last run |

## Verification
A wrong validation step or a wrong direction of search does not hide. The run ends with a different final setting or a different adjustment count, and both are visible as soon as `done_o` or `fail_o` pulses. An error in the attempt or budget bookkeeping shows up differently: the block fails where it should succeed, or reports the wrong count. The comparator model in the bench uses the setting latched at each `load_o` inversion. A strobe placed too early, or a sample taken from a stale setting, therefore changes the path of the search within a few trials.

// File: rtl/phalign_pkg.sv
package phalign_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_FINAL
  } trial_e;

  typedef enum logic [2:0] {
    SP_SEEK,
    SP_FWD,
    SP_BACK_A,
    SP_BACK_B,
    SP_RESEEK,
    SP_TRACK
  } step_e;
endpackage

// File: rtl/phalign_settle.sv
module phalign_settle #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [W-1:0] cnt_q;

  assign expired = run && (cnt_q == W'(SETTLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/phalign_adjcnt.sv
module phalign_adjcnt #(
  parameter int CW      = 16,
  parameter int MAX_ADJ = 65535
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          last
);
  assign last = (count == CW'(MAX_ADJ - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc && count != CW'(MAX_ADJ)) count <= count + 1'b1;
  end

  p_cnt_cap_r7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(MAX_ADJ));
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(MAX_ADJ)) && !clr |=> count == CW'(MAX_ADJ));
endmodule

// File: rtl/phase_align_seq.sv
module phase_align_seq #(
  parameter int PH_W         = 6,
  parameter int SETTLE_CYC   = 2,
  parameter int CNT_W        = 16,
  parameter int MAX_ADJ      = 65535,
  parameter int MAX_TRIES    = 10,
  parameter int FWD_STEPS    = 5,
  parameter int BACK_A_STEPS = 3,
  parameter int BACK_B_STEPS = 5,
  parameter int ST_W         = 5,
  parameter int ST_TARGET    = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             cmp_i,
  input  logic [ST_W-1:0]  status_i,
  input  logic [PH_W-1:0]  init_phase_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             load_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] adj_count_o
);
  import phalign_pkg::*;

  localparam int MAX_STEPS = (FWD_STEPS > BACK_B_STEPS) ?
                             ((FWD_STEPS > BACK_A_STEPS) ? FWD_STEPS : BACK_A_STEPS) :
                             ((BACK_B_STEPS > BACK_A_STEPS) ? BACK_B_STEPS : BACK_A_STEPS);
  localparam int SUB_W = $clog2(MAX_STEPS + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam int GAP_W = $clog2(SETTLE_CYC + 2);

  trial_e            state_q;
  step_e             step_q;
  logic [PH_W-1:0]   phase_q;
  logic              prev_q;
  logic [SUB_W-1:0]  sub_q;
  logic [TRY_W-1:0]  try_q;
  logic              load_q, done_q, fail_q;

  logic settle_run, settle_exp;
  logic cnt_clr, cnt_inc, cnt_last;
  logic edge_seen, track_hit, restart_req, take_start;

  assign settle_run = (state_q == ST_SETTLE) || (state_q == ST_FINAL);
  assign take_start = (state_q == ST_IDLE) && start_i;
  assign cnt_clr    = take_start;
  assign cnt_inc    = (state_q == ST_SAMPLE);

  phalign_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .run(settle_run), .expired(settle_exp)
  );

  phalign_adjcnt #(.CW(CNT_W), .MAX_ADJ(MAX_ADJ)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .count(adj_count_o), .last(cnt_last)
  );

  always_comb begin
    edge_seen   = prev_q && !cmp_i;
    track_hit   = (step_q == SP_TRACK) && (status_i == ST_W'(ST_TARGET));
    restart_req = 1'b0;
    unique case (step_q)
      SP_FWD:    restart_req = cmp_i;
      SP_BACK_A: restart_req = cmp_i;
      SP_BACK_B: restart_req = (sub_q == SUB_W'(BACK_B_STEPS - 1)) && !cmp_i;
      default:   restart_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= SP_SEEK;
      phase_q <= '0;
      prev_q  <= 1'b0;
      sub_q   <= '0;
      try_q   <= '0;
      load_q  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          phase_q <= init_phase_i;
          step_q  <= mode_i ? SP_TRACK : SP_SEEK;
          prev_q  <= 1'b0;
          sub_q   <= '0;
          try_q   <= '0;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_exp) begin
          load_q  <= ~load_q;
          state_q <= ST_SAMPLE;
        end
        ST_FINAL: if (settle_exp) begin
          load_q  <= ~load_q;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_SAMPLE: begin
          if (track_hit) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (step_q == SP_RESEEK && edge_seen) begin
            phase_q <= phase_q - 1'b1;
            state_q <= ST_FINAL;
          end else if (cnt_last) begin
            fail_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (restart_req) begin
            if (try_q == TRY_W'(MAX_TRIES - 1)) begin
              fail_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              try_q   <= try_q + 1'b1;
              step_q  <= SP_SEEK;
              prev_q  <= 1'b0;
              sub_q   <= '0;
              state_q <= ST_SETTLE;
            end
          end else begin
            state_q <= ST_SETTLE;
            unique case (step_q)
              SP_SEEK, SP_RESEEK: begin
                if (edge_seen) begin
                  step_q  <= SP_FWD;
                  sub_q   <= '0;
                  phase_q <= phase_q + 1'b1;
                end else begin
                  phase_q <= cmp_i ? phase_q + 1'b1 : phase_q - 1'b1;
                  prev_q  <= cmp_i;
                end
              end
              SP_FWD: begin
                if (sub_q == SUB_W'(FWD_STEPS - 1)) begin
                  step_q  <= SP_BACK_A;
                  sub_q   <= '0;
                  phase_q <= phase_q - 1'b1;
                end else begin
                  sub_q   <= sub_q + 1'b1;
                  phase_q <= phase_q + 1'b1;
                end
              end
              SP_BACK_A: begin
                if (sub_q == SUB_W'(BACK_A_STEPS - 1)) begin
                  step_q <= SP_BACK_B;
                  sub_q  <= '0;
                end else begin
                  sub_q <= sub_q + 1'b1;
                end
                phase_q <= phase_q - 1'b1;
              end
              SP_BACK_B: begin
                if (sub_q == SUB_W'(BACK_B_STEPS - 1)) begin
                  step_q <= SP_RESEEK;
                  prev_q <= 1'b0;
                  sub_q  <= '0;
                end else begin
                  sub_q   <= sub_q + 1'b1;
                  phase_q <= phase_q - 1'b1;
                end
              end
              default: begin
                phase_q <= (status_i > ST_W'(ST_TARGET)) ? phase_q + 1'b1 : phase_q - 1'b1;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign load_o  = load_q;
  assign done_o  = done_q;
  assign fail_o  = fail_q;

  // Checker state: edges since phase_o took its present value, saturating.
  logic [PH_W-1:0]  ph_seen_q;
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_seen_q <= '0;
      gap_q     <= GAP_W'(SETTLE_CYC);
    end else begin
      ph_seen_q <= phase_o;
      if (phase_o != ph_seen_q) gap_q <= GAP_W'(1);
      else if (gap_q != GAP_W'(SETTLE_CYC)) gap_q <= gap_q + 1'b1;
    end
  end

  p_settle_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (load_o != $past(load_o)) |-> (gap_q >= GAP_W'(SETTLE_CYC)) && $past(settle_exp));
  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) != ST_IDLE) && (phase_o != $past(phase_o)) |->
      (phase_o == $past(phase_o) + 1'b1) || (phase_o == $past(phase_o) - 1'b1));
  p_final_load_r5: assert property (@(posedge clk) disable iff (rst)
    done_o && ($past(state_q) == ST_FINAL) |-> load_o != $past(load_o));
  p_track_hit_r8: assert property (@(posedge clk) disable iff (rst)
    done_o && ($past(state_q) == ST_SAMPLE) |-> $past(status_i) == ST_W'(ST_TARGET));
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_fail_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> !fail_o);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=>
      (adj_count_o == $past(adj_count_o)) || (adj_count_o == $past(adj_count_o) + 1'b1));
endmodule

// File: tb/phase_align_seq_tb.sv
module phase_align_seq_tb;
  localparam int SETTLE = 3;
  localparam int BUDGET = 600;

  typedef struct packed {
    logic        mode;
    logic [63:0] mask;
    logic [5:0]  tgt;
    logic [5:0]  init;
    logic        ok;
    logic [5:0]  ph;
    logic [15:0] cnt;
  } vec_t;

  localparam int NV = 10;
  // mask bit p = comparator reading at setting p (edge mode)
  localparam vec_t VECS [NV] = '{
    '{1'b0, 64'hFFF00000000FFFFF, 6'd0,  6'd20, 1'b1, 6'd19, 16'd20},  // R5 start on edge
    '{1'b0, 64'hFFF00000000FFFFF, 6'd0,  6'd0,  1'b1, 6'd19, 16'd38},  // R3 climbing
    '{1'b0, 64'hFFF00000000FFFFF, 6'd0,  6'd40, 1'b1, 6'd19, 16'd40},  // R3 descending
    '{1'b0, 64'hFFFFFFFF00000000, 6'd0,  6'd0,  1'b1, 6'd63, 16'd20},  // R10 wrap
    '{1'b0, 64'hFFFFFFFFFFFFE3FF, 6'd0,  6'd10, 1'b0, 6'd0,  16'd591}, // R6 narrow window
    '{1'b0, 64'hFFFFFFFFFFFF037F, 6'd0,  6'd10, 1'b0, 6'd0,  16'd100}, // R4 step-3 false edge
    '{1'b0, 64'hFFFFFFFFFFFFFFFF, 6'd0,  6'd5,  1'b0, 6'd0,  16'd600}, // R7 budget
    '{1'b1, 64'h0,                6'd30, 6'd25, 1'b1, 6'd30, 16'd6},   // R8 up
    '{1'b1, 64'h0,                6'd30, 6'd33, 1'b1, 6'd30, 16'd4},   // R8 down
    '{1'b1, 64'h0,                6'd30, 6'd30, 1'b1, 6'd30, 16'd1}    // R8 immediate
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [5:0] init = '0;
  logic [5:0] phase;
  logic load, done, fail;
  logic [15:0] cnt;
  logic cmp;
  logic [4:0] status;

  logic [63:0] cur_mask = '0;
  logic [5:0]  cur_tgt = '0;
  logic [5:0]  applied = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // Delay line model: takes the setting on every load inversion.
  always @(load) applied = phase;
  assign cmp    = cur_mask[applied];
  assign status = (applied > cur_tgt) ? 5'd5 : (applied < cur_tgt) ? 5'd20 : 5'd15;

  phase_align_seq #(.SETTLE_CYC(SETTLE), .MAX_ADJ(BUDGET)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(mode), .cmp_i(cmp),
    .status_i(status), .init_phase_i(init), .phase_o(phase), .load_o(load),
    .done_o(done), .fail_o(fail), .adj_count_o(cnt)
  );

  // Settle-gap monitor for R2
  logic [5:0] last_ph = '0;
  logic       last_ld = 1'b0;
  int since = 0;
  int min_gap = 1000;
  always @(negedge clk) begin
    cycles++;
    if (phase != last_ph) since = 0; else since++;
    if (!rst && load != last_ld && since < min_gap) min_gap = since;
    last_ph = phase;
    last_ld = load;
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic m, input logic [63:0] mk, input logic [5:0] tg,
                          input logic [5:0] ip, output bit ok, output bit bad,
                          output logic [5:0] ph, output logic [15:0] c, output bit tout);
    cur_mask = mk;
    cur_tgt  = tg;
    @(negedge clk);
    mode = m; init = ip; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tout = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done || fail) begin
        tout = 1'b0;
        break;
      end
    end
    ok = done; bad = fail; ph = phase; c = cnt;
  endtask

  initial begin
    bit ok, bad, tout;
    logic [5:0] ph;
    logic [15:0] c;
    string tag;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(phase == 6'd0 && load == 1'b0, "R1 phase/load", {phase, load}, 0);
    check(!done && !fail && cnt == 16'd0, "R1 done/fail/count", {done, fail, cnt}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      tag = $sformatf("vector %0d (R3/R4/R5/R6/R7/R8/R10)", v);
      run_case(VECS[v].mode, VECS[v].mask, VECS[v].tgt, VECS[v].init, ok, bad, ph, c, tout);
      check(!tout, {tag, " finished"}, int'(tout), 0);
      check(ok == VECS[v].ok && bad == !VECS[v].ok, {tag, " outcome"}, int'(ok), int'(VECS[v].ok));
      check(c == VECS[v].cnt, {tag, " count"}, c, VECS[v].cnt);
      if (VECS[v].ok) begin
        check(ph == VECS[v].ph, {tag, " phase"}, ph, VECS[v].ph);
        check(applied == VECS[v].ph, {tag, " loaded setting R5"}, applied, VECS[v].ph);
      end
      @(negedge clk);
      check(!done && !fail, "R9 single-cycle pulse", {done, fail}, 0);
    end

    // R9: start while busy is ignored; outputs hold after finish
    cur_mask = 64'hFFF00000000FFFFF;
    @(negedge clk);
    mode = 1'b0; init = 6'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    init = 6'd40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tout = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done || fail) begin tout = 1'b0; break; end
    end
    check(done && !tout, "R9 busy start run completes", int'(done), 1);
    check(phase == 6'd19 && cnt == 16'd20, "R9 busy start ignored", {phase, cnt}, {6'd19, 16'd20});
    repeat (6) @(negedge clk);
    check(phase == 6'd19 && cnt == 16'd20 && !done, "R9 outputs held", {phase, cnt}, {6'd19, 16'd20});

    // R2 settle interval between setting change and load inversion
    check(min_gap == SETTLE, "R2 settle gap", min_gap, SETTLE);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule